// File: doc/BRIEF.md
# LED Matrix Scan Timing Controller

This block produces every timing signal needed by a 1/16-scan dot-matrix LED driver board built from 8x8 modules with red and green emitters. A free-running divider turns the fast system clock into a slow row-rate tick. Each tick starts one row period.

In each row period the controller reads the next row's pixels from a synchronous frame buffer read port, one column per read. It shifts the pixels out on two serial column lines, one red and one green, under a shared shift clock. It then blanks the panel, strobes the column latches and moves a walking token one place along the board's row shift register. Finally it lights the panel again.

Only one of the 16 rows is lit at any time. Latching and row changes happen only while the panel is dark, so no ghost image appears. The board's row shift register is expected to be cleared by the same reset as this block.

Top module: `led_scan_ctrl`

## Requirements
- R1: Row periods start on a tick that occurs once every CLK_DIV system clocks. Consecutive latch pulses are therefore exactly CLK_DIV clocks apart. CLK_DIV must be at least 2*COLS+10.
- R2: In every row period exactly COLS bits leave on each of `col_red` and `col_green`, column 0 first. After the last shift, the column register holds the frame buffer row that is about to be lit, with column c at bit position COLS-1-c.
- R3: A new column bit appears only when `col_clk` falls or is low, and it is stable across each `col_clk` rising edge. `col_clk` is high for one system clock and low for at least one.
- R4: The frame buffer address is {row, column}, with the row in the upper ROW_W bits. Read data is taken one clock after `fb_rd_en`, with bit 0 as red and bit 1 as green.
- R5: `col_oe_n` is active low. It is high during every latch pulse and every row shift clock pulse. It goes high at least two clocks before the latch pulse and stays high for at least two clocks after `row_clk` falls.
- R6: `col_latch` is a single-clock pulse, issued once per row period after the last column shift and before the row shift.
- R7: `row_data` is 1 for the shift that selects row 0 and 0 for the shifts that select rows 1 to 15. While lit, the row register therefore holds exactly one 1, at bit position equal to the row index. Rows are visited 0,1,...,15 and then wrap.
- R8: `frame_start` is high for one clock, together with the `row_clk` pulse that shifts in the token for row 0, and at no other time.
- R9: Synchronous reset drives `col_oe_n` high and all strobes and `fb_rd_en` low, and restarts the divider. The first row lit after reset is row 0, and no column shift occurs within CLK_DIV/2 clocks of reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_rd_en | output | 1 | Frame buffer read request |
| fb_rd_addr | output | ROW_W+COL_W | Frame buffer address {row, column} |
| fb_rd_data | input | 2 | Pixel read one clock after request; bit 0 red, bit 1 green |
| col_red | output | 1 | Serial red column data |
| col_green | output | 1 | Serial green column data |
| col_clk | output | 1 | Column shift clock, rising edge shifts |
| col_latch | output | 1 | Column parallel latch strobe |
| col_oe_n | output | 1 | Column output enable, active low |
| row_data | output | 1 | Serial row token data |
| row_clk | output | 1 | Row shift clock, rising edge shifts |
| frame_start | output | 1 | One-clock pulse when row 0 is selected |

## Verification
The bench builds the block with CLK_DIV=60 and MODULES=2, which gives 16 columns and a row period of 60 clocks. A full 16-row frame therefore takes under a thousand clocks, so several complete frames, each with a different fill pattern, and a reset in the middle of a row all fit in a short run. The bench models the board's column and row shift registers from the strobes alone. It compares each latched row against the frame buffer image and checks the single-token row register at every unblank. It also times the blanking guard windows and the latch spacing against CLK_DIV.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

    // Sequencer steps of one row period
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOAD,
        ST_HIGH,
        ST_BLANK,
        ST_PRE_LATCH,
        ST_LATCH,
        ST_ROW_SET,
        ST_ROW_HIGH,
        ST_ROW_LOW,
        ST_POST,
        ST_UNBLANK
    } scan_state_e;

    // One pixel as read from the frame buffer
    typedef struct packed {
        logic green;
        logic red;
    } pix_t;

    localparam int unsigned PIX_PER_MODULE = 8;

    // Clocks a row period needs beyond the tick slot
    function automatic int unsigned row_cycles(input int unsigned cols);
        return 2 * cols + 10;
    endfunction

    function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
        return (v == n - 1) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
    parameter int unsigned CLK_DIV = 100
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end

    // Tick is a single-clock pulse
    assert_tick_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/led_row_tracker.sv
module led_row_tracker #(
    parameter int unsigned ROWS  = 16,
    parameter int unsigned ROW_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [ROW_W-1:0] cur_row,
    output logic [ROW_W-1:0] next_row,
    output logic             token_bit
);
    import led_scan_pkg::*;

    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    // Reset parks on the last row so that the first row shown is row 0
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_row <= LAST_ROW;
        end else if (advance) begin
            cur_row <= next_row;
        end
    end

    always_comb begin
        next_row  = ROW_W'(wrap_inc(int'(cur_row), ROWS));
        token_bit = (next_row == '0);
    end

    assert_row_range_R7: assert property (@(posedge clk) disable iff (rst)
        cur_row <= LAST_ROW);

    assert_row_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (advance && cur_row == LAST_ROW) |=> cur_row == '0);

endmodule

// File: rtl/led_scan_fsm.sv
module led_scan_fsm
    import led_scan_pkg::*;
#(
    parameter int unsigned COLS  = 32,
    parameter int unsigned ROW_W = 4,
    parameter int unsigned COL_W = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick,
    input  logic [ROW_W-1:0]       next_row,
    input  logic                   token_bit,
    input  pix_t                   fb_pix,
    output logic                   fb_rd_en,
    output logic [ROW_W+COL_W-1:0] fb_rd_addr,
    output logic                   advance,
    output logic                   col_red,
    output logic                   col_green,
    output logic                   col_clk,
    output logic                   col_latch,
    output logic                   col_oe_n,
    output logic                   row_data,
    output logic                   row_clk,
    output logic                   frame_start
);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

    scan_state_e      state_q, state_d;
    logic [COL_W-1:0] col_q, col_d, rd_col;

    // Step sequencing and read requests
    always_comb begin
        state_d  = state_q;
        col_d    = col_q;
        rd_col   = col_q;
        fb_rd_en = 1'b0;
        advance  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tick) begin
                    fb_rd_en = 1'b1;
                    rd_col   = '0;
                    col_d    = '0;
                    state_d  = ST_LOAD;
                end
            end
            ST_LOAD:      state_d = ST_HIGH;
            ST_HIGH: begin
                if (col_q == LAST_COL) begin
                    state_d = ST_BLANK;
                end else begin
                    fb_rd_en = 1'b1;
                    rd_col   = col_q + 1'b1;
                    col_d    = col_q + 1'b1;
                    state_d  = ST_LOAD;
                end
            end
            ST_BLANK:     state_d = ST_PRE_LATCH;
            ST_PRE_LATCH: state_d = ST_LATCH;
            ST_LATCH:     state_d = ST_ROW_SET;
            ST_ROW_SET:   state_d = ST_ROW_HIGH;
            ST_ROW_HIGH: begin
                advance = 1'b1;
                state_d = ST_ROW_LOW;
            end
            ST_ROW_LOW:   state_d = ST_POST;
            ST_POST:      state_d = ST_UNBLANK;
            ST_UNBLANK:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
        fb_rd_addr = {next_row, rd_col};
    end

    // Registered panel strobes
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            col_q       <= '0;
            col_red     <= 1'b0;
            col_green   <= 1'b0;
            col_clk     <= 1'b0;
            col_latch   <= 1'b0;
            col_oe_n    <= 1'b1;
            row_data    <= 1'b0;
            row_clk     <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            state_q     <= state_d;
            col_q       <= col_d;
            col_latch   <= 1'b0;
            frame_start <= 1'b0;
            case (state_q)
                ST_LOAD: begin
                    col_red   <= fb_pix.red;
                    col_green <= fb_pix.green;
                    col_clk   <= 1'b0;
                end
                ST_HIGH:     col_clk <= 1'b1;
                ST_BLANK: begin
                    col_clk  <= 1'b0;
                    col_oe_n <= 1'b1;
                end
                ST_LATCH:    col_latch <= 1'b1;
                ST_ROW_SET:  row_data  <= token_bit;
                ST_ROW_HIGH: begin
                    row_clk     <= 1'b1;
                    frame_start <= token_bit;
                end
                ST_ROW_LOW:  row_clk  <= 1'b0;
                ST_UNBLANK:  col_oe_n <= 1'b0;
                default: ;
            endcase
        end
    end

    assert_latch_dark_R5: assert property (@(posedge clk) disable iff (rst)
        col_latch |-> col_oe_n);

    assert_rowclk_dark_R5: assert property (@(posedge clk) disable iff (rst)
        row_clk |-> col_oe_n);

    assert_latch_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        col_latch |=> !col_latch);

    assert_data_stable_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(col_clk) |-> ($stable(col_red) && $stable(col_green)));

    assert_clk_half_rate_R3: assert property (@(posedge clk) disable iff (rst)
        col_clk |=> !col_clk);

    assert_frame_token_R8: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (row_clk && row_data));

    assert_reset_dark_R9: assert property (@(posedge clk)
        rst |=> (col_oe_n && !col_latch && !row_clk && !col_clk));

endmodule

// File: rtl/led_scan_ctrl.sv
module led_scan_ctrl
    import led_scan_pkg::*;
#(
    parameter int unsigned CLK_DIV = 100,
    parameter int unsigned MODULES = 4,
    parameter int unsigned ROWS    = 16,
    localparam int unsigned COLS   = MODULES * PIX_PER_MODULE,
    localparam int unsigned ROW_W  = $clog2(ROWS),
    localparam int unsigned COL_W  = $clog2(COLS),
    localparam int unsigned ADDR_W = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst,
    output logic              fb_rd_en,
    output logic [ADDR_W-1:0] fb_rd_addr,
    input  logic [1:0]        fb_rd_data,
    output logic              col_red,
    output logic              col_green,
    output logic              col_clk,
    output logic              col_latch,
    output logic              col_oe_n,
    output logic              row_data,
    output logic              row_clk,
    output logic              frame_start
);
    logic             tick;
    logic             advance;
    logic             token_bit;
    logic [ROW_W-1:0] cur_row;
    logic [ROW_W-1:0] next_row;
    pix_t             fb_pix;

    assign fb_pix = pix_t'(fb_rd_data);

    led_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    led_row_tracker #(.ROWS(ROWS), .ROW_W(ROW_W)) u_rows (
        .clk       (clk),
        .rst       (rst),
        .advance   (advance),
        .cur_row   (cur_row),
        .next_row  (next_row),
        .token_bit (token_bit)
    );

    led_scan_fsm #(.COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .next_row    (next_row),
        .token_bit   (token_bit),
        .fb_pix      (fb_pix),
        .fb_rd_en    (fb_rd_en),
        .fb_rd_addr  (fb_rd_addr),
        .advance     (advance),
        .col_red     (col_red),
        .col_green   (col_green),
        .col_clk     (col_clk),
        .col_latch   (col_latch),
        .col_oe_n    (col_oe_n),
        .row_data    (row_data),
        .row_clk     (row_clk),
        .frame_start (frame_start)
    );

    // Row index moves only on the row shift pulse
    assert_row_moves_on_shift_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_row) |-> $past(advance));

endmodule

// File: tb/tb_led_scan_ctrl.sv
module tb_led_scan_ctrl;
    localparam int unsigned CLK_DIV = 60;
    localparam int unsigned MODULES = 2;
    localparam int unsigned ROWS    = 16;
    localparam int unsigned COLS    = MODULES * 8;
    localparam int unsigned ROW_W   = $clog2(ROWS);
    localparam int unsigned COL_W   = $clog2(COLS);
    localparam int unsigned ADDR_W  = ROW_W + COL_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic              fb_rd_en;
    logic [ADDR_W-1:0] fb_rd_addr;
    logic [1:0]        fb_q = 2'b00;
    logic col_red, col_green, col_clk, col_latch, col_oe_n;
    logic row_data, row_clk, frame_start;

    always #10 clk = ~clk;

    led_scan_ctrl #(.CLK_DIV(CLK_DIV), .MODULES(MODULES), .ROWS(ROWS)) dut (
        .clk(clk), .rst(rst), .fb_rd_en(fb_rd_en), .fb_rd_addr(fb_rd_addr),
        .fb_rd_data(fb_q), .col_red(col_red), .col_green(col_green),
        .col_clk(col_clk), .col_latch(col_latch), .col_oe_n(col_oe_n),
        .row_data(row_data), .row_clk(row_clk), .frame_start(frame_start)
    );

    logic [1:0] fb [ROWS][COLS];
    int tests = 0;
    int fails = 0;
    bit done = 0;

    // Frame buffer with one-clock read latency (R4)
    always @(posedge clk) begin
        if (fb_rd_en) fb_q <= fb[fb_rd_addr[ADDR_W-1:COL_W]][fb_rd_addr[COL_W-1:0]];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic fill(input int kind);
        for (int r = 0; r < int'(ROWS); r++) begin
            for (int c = 0; c < int'(COLS); c++) begin
                case (kind)
                    1:       fb[r][c] = 2'b11;
                    2:       fb[r][c] = ((r + c) % 2 == 0) ? 2'b01 : 2'b10;
                    3:       fb[r][c] = (c == 0 || c == int'(COLS) - 1) ? 2'b11 : 2'b00;
                    default: fb[r][c] = 2'($urandom);
                endcase
            end
        end
    endtask

    function automatic logic [COLS-1:0] exp_line(input int r, input int bitsel);
        logic [COLS-1:0] v;
        for (int c = 0; c < int'(COLS); c++) v[COLS-1-c] = fb[r][c][bitsel];
        return v;
    endfunction

    // Board model state
    logic [COLS-1:0] red_sr, grn_sr;
    logic [ROWS-1:0] row_sr;
    int   shift_cnt, exp_row, shown_row, oe_run, cyc, last_latch, rfall_cyc;
    int   post_cnt, early_rises, frames;
    bit   have_latch;
    logic p_cclk, p_red, p_grn, p_rclk, p_latch, p_oe;

    initial begin
        frames = 0;
        cyc = 0;
    end

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            red_sr = '0; grn_sr = '0; row_sr = '0;
            shift_cnt = 0; exp_row = 0; shown_row = 0; oe_run = 0;
            have_latch = 0; post_cnt = 0; early_rises = 0; rfall_cyc = 0;
            p_cclk = 0; p_red = 0; p_grn = 0; p_rclk = 0; p_latch = 0; p_oe = 1;
        end else if (!done) begin
            post_cnt++;
            if (col_oe_n) oe_run++; else oe_run = 0;
            if (col_clk && !p_cclk) begin
                check(col_red == p_red && col_green == p_grn, "R3 data stable at shift edge",
                      {col_green, col_red}, {p_grn, p_red});
                red_sr = {red_sr[COLS-2:0], col_red};
                grn_sr = {grn_sr[COLS-2:0], col_green};
                shift_cnt++;
                if (post_cnt <= int'(CLK_DIV / 2)) early_rises++;
            end
            if (post_cnt == int'(CLK_DIV / 2))
                check(early_rises == 0, "R9 no shift right after reset", early_rises, 0);
            if (col_latch && !p_latch) begin
                check(shift_cnt == int'(COLS), "R2 shift count per row", shift_cnt, COLS);
                check(red_sr == exp_line(exp_row, 0), "R2 R4 red row contents",
                      int'(red_sr), int'(exp_line(exp_row, 0)));
                check(grn_sr == exp_line(exp_row, 1), "R2 R4 green row contents",
                      int'(grn_sr), int'(exp_line(exp_row, 1)));
                check(oe_run >= 3, "R5 blank lead before latch", oe_run - 1, 2);
                if (have_latch)
                    check(cyc - last_latch == int'(CLK_DIV), "R1 row period", cyc - last_latch, CLK_DIV);
                have_latch = 1;
                last_latch = cyc;
                shift_cnt = 0;
            end
            if (col_latch && p_latch) check(0, "R6 latch width", 2, 1);
            if (row_clk && !p_rclk) begin
                check(row_data == (exp_row == 0), "R7 token bit", row_data, exp_row == 0);
                check(col_oe_n, "R5 dark during row shift", col_oe_n, 1);
                check(shift_cnt == 0, "R6 latch precedes row shift", shift_cnt, 0);
                check(frame_start == (exp_row == 0), "R8 frame start on row 0", frame_start, exp_row == 0);
                row_sr = {row_sr[ROWS-2:0], row_data};
                shown_row = exp_row;
                exp_row = (exp_row + 1) % int'(ROWS);
                if (frame_start) begin
                    frames++;
                    fill(frames % 4);
                end
            end else if (frame_start) begin
                check(0, "R8 stray frame start", 1, 0);
            end
            if (!row_clk && p_rclk) rfall_cyc = cyc;
            if (!col_oe_n && p_oe) begin
                check(row_sr == (ROWS'(1) << shown_row), "R7 single lit row",
                      int'(row_sr), 1 << shown_row);
                check(cyc - rfall_cyc >= 2, "R5 blank tail after row shift", cyc - rfall_cyc, 2);
            end
            p_cclk = col_clk; p_red = col_red; p_grn = col_green;
            p_rclk = row_clk; p_latch = col_latch; p_oe = col_oe_n;
        end
    end

    task automatic check_reset_outputs();
        check(col_oe_n == 1'b1, "R9 reset blanks", col_oe_n, 1);
        check({col_latch, col_clk, row_clk, frame_start, fb_rd_en} == 5'b0,
              "R9 reset strobes low", {col_latch, col_clk, row_clk, frame_start, fb_rd_en}, 0);
    endtask

    initial begin
        void'($urandom(32'h1A2B3C4D));
        fill(0);
        rst = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check_reset_outputs();
        rst = 1'b0;
        wait (frames >= 5);
        repeat ($urandom_range(5, 3 * CLK_DIV)) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_outputs();
        rst = 1'b0;
        wait (frames >= 7);
        repeat (CLK_DIV) @(posedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", frames, 7);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule